// File: doc/BRIEF.md
# Contended Lock Limiter Identifier

This block watches lock activity that the cores of a chip report one event at a time: a thread taking a lock, a thread giving a lock back, and a thread starting or stopping a wait on a lock. It keeps a small table of the locks it has seen. For each lock it counts how many threads are waiting, and it adds that count every cycle. The result is a measure of the total thread-cycles lost to that lock in the current measurement interval.

At the end of every interval the block picks the lock with the largest accumulated waiting time. It then marks the thread that currently owns that lock as the limiter, the thread most likely to sit on the critical path. The mark is a per-thread flag vector that the memory request scheduler reads to raise the priority of that thread's requests. The flags hold for the whole next interval. The table entries are then either kept or recycled, and all waiting totals start again from zero.

Events enter on a valid/ready interface. The block never buffers an event. It deasserts `evt_ready` for exactly one cycle per interval, the cycle in which the selection is made. An event offered in that cycle is not taken, and the producer must hold it or give it up. In every other cycle `evt_ready` is high and an event is taken in any cycle where `evt_valid` is high.

Top module: `lock_limiter_id`

## Requirements
- R1: `evt_ready` is low in exactly one cycle per interval, the selection cycle, which comes `INTERVAL`-1 cycles after the cycle in which `limiter_upd` is high; an event offered while `evt_ready` is low changes no state.
- R2: `evt_kind` encodings are 0 = take lock, 1 = give lock back, 2 = begin waiting, 3 = stop waiting; taking a lock also ends that thread's wait on it. A thread counts as waiting from the cycle after its begin-wait is taken up to and including the cycle in which its stop-wait or take is taken.
- R3: Selection happens every `INTERVAL` cycles, the first one `INTERVAL`-1 cycles after reset ends; `limiter_flags` change only in the cycle after a selection, together with a one-cycle pulse on `limiter_upd`, and otherwise hold their value.
- R4: At selection the entry with the largest waiting total is chosen, and bit `t` of `limiter_flags` is set, where `t` is the thread that owns that lock; at most one flag is set.
- R5: When several entries share the largest total, the one with the lowest table index wins; new locks take the lowest free index.
- R6: If the chosen lock has no owner, or no lock gathered any waiting time in the interval, all flags are zero for the next interval.
- R7: All waiting totals restart from zero after each selection, so waiting in one interval has no weight in the next.
- R8: A waiting total saturates at 2^`ACC_W`-1 instead of wrapping.
- R9: A give-back from a thread that does not own the lock is ignored.
- R10: An event for an untracked lock claims a free entry; if none is free the event is dropped. At selection, an entry whose lock has no owner and no waiters is freed.
- R11: After reset all flags are zero, `evt_ready` is high and no lock is tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A lock event is offered |
| evt_ready | output | 1 | The block takes the offered event this cycle |
| evt_kind | input | 2 | Event type: 0 take, 1 give back, 2 begin wait, 3 stop wait |
| evt_thread | input | $clog2(N_THREADS) | Thread that caused the event |
| evt_lock | input | LOCK_W | Identifier of the lock concerned |
| limiter_flags | output | N_THREADS | One bit per thread; a set bit marks the limiter thread |
| limiter_upd | output | 1 | One-cycle pulse when a new flag vector is in place |

## Verification
The bench builds the block with 4 threads, 4 table entries, a 6-bit waiting total and a 64-cycle interval. With four entries the table fills in a handful of events, so the drop of an event for a new lock is reachable. A 6-bit total saturates when two threads wait for half an interval, which lets a tie between two saturated totals tell saturation apart from wrap-around. The short interval lets one run cover eight back-to-back selections, including waits that cross a boundary and an event offered in the selection cycle.

// File: rtl/lli_pkg.sv
package lli_pkg;

  typedef enum logic [1:0] {
    EV_TAKE       = 2'd0,
    EV_GIVE       = 2'd1,
    EV_WAIT_BEGIN = 2'd2,
    EV_WAIT_STOP  = 2'd3
  } lock_ev_e;

endpackage

// File: rtl/lli_interval_timer.sv
module lli_interval_timer #(
  parameter int INTERVAL = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic boundary
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt;

  assign boundary = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (boundary) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lli_lock_entry.sv
module lli_lock_entry
  import lli_pkg::*;
#(
  parameter int N_THREADS = 16,
  parameter int LOCK_W    = 32,
  parameter int ACC_W     = 24,
  parameter int TID_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              apply,
  input  logic              alloc,
  input  logic [1:0]        kind,
  input  logic [TID_W-1:0]  tid,
  input  logic [LOCK_W-1:0] lock_in,
  output logic              busy,
  output logic [LOCK_W-1:0] lock_id,
  output logic              owned,
  output logic [TID_W-1:0]  owner,
  output logic [ACC_W-1:0]  wait_acc
);
  localparam int CNT_W = $clog2(N_THREADS + 1);

  logic [N_THREADS-1:0] waiters;
  logic [N_THREADS-1:0] n_wait;
  logic                 n_owned;
  logic [TID_W-1:0]     n_owner;
  logic [CNT_W-1:0]     wcnt;
  logic [ACC_W:0]       sum;
  logic [ACC_W-1:0]     acc_next;

  // number of threads waiting on this lock in the current cycle
  always_comb begin
    wcnt = '0;
    for (int t = 0; t < N_THREADS; t++) begin
      wcnt = wcnt + CNT_W'(waiters[t]);
    end
  end

  assign sum      = {1'b0, wait_acc} + (ACC_W + 1)'(wcnt);
  assign acc_next = sum[ACC_W] ? '1 : sum[ACC_W-1:0];

  // effect of the accepted event on ownership and waiter set
  always_comb begin
    n_owned = alloc ? 1'b0 : owned;
    n_owner = owner;
    n_wait  = alloc ? '0 : waiters;
    if (apply) begin
      unique case (lock_ev_e'(kind))
        EV_TAKE: begin
          n_owned     = 1'b1;
          n_owner     = tid;
          n_wait[tid] = 1'b0;
        end
        EV_GIVE: begin
          if (n_owned && (n_owner == tid)) n_owned = 1'b0;
        end
        EV_WAIT_BEGIN: n_wait[tid] = 1'b1;
        EV_WAIT_STOP:  n_wait[tid] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      lock_id  <= '0;
      owned    <= 1'b0;
      owner    <= '0;
      waiters  <= '0;
      wait_acc <= '0;
    end else if (boundary) begin
      wait_acc <= '0;
      if (!owned && (waiters == '0)) busy <= 1'b0;
    end else begin
      wait_acc <= acc_next;
      if (apply) begin
        busy    <= 1'b1;
        owned   <= n_owned;
        owner   <= n_owner;
        waiters <= n_wait;
        if (alloc) lock_id <= lock_in;
      end
    end
  end
endmodule

// File: rtl/lli_max_select.sv
module lli_max_select #(
  parameter int N_ENTRIES = 8,
  parameter int ACC_W     = 24,
  parameter int EIDX_W    = 3
) (
  input  logic [N_ENTRIES-1:0][ACC_W-1:0] vals,
  output logic [EIDX_W-1:0]               idx,
  output logic [ACC_W-1:0]                best
);
  // strict comparison keeps the lowest index on equal totals
  always_comb begin
    idx  = '0;
    best = vals[0];
    for (int i = 1; i < N_ENTRIES; i++) begin
      if (vals[i] > best) begin
        best = vals[i];
        idx  = EIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lock_limiter_id.sv
module lock_limiter_id #(
  parameter int N_THREADS = 16,
  parameter int N_ENTRIES = 8,
  parameter int LOCK_W    = 32,
  parameter int ACC_W     = 24,
  parameter int INTERVAL  = 100000,
  localparam int TID_W    = (N_THREADS > 2) ? $clog2(N_THREADS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic [1:0]           evt_kind,
  input  logic [TID_W-1:0]     evt_thread,
  input  logic [LOCK_W-1:0]    evt_lock,
  output logic [N_THREADS-1:0] limiter_flags,
  output logic                 limiter_upd
);
  localparam int EIDX_W = (N_ENTRIES > 2) ? $clog2(N_ENTRIES) : 1;

  logic                              boundary;
  logic                              fire;
  logic                              hit;
  logic [N_ENTRIES-1:0]              match;
  logic [N_ENTRIES-1:0]              busy;
  logic [N_ENTRIES-1:0]              owned;
  logic [N_ENTRIES-1:0]              alloc_oh;
  logic [N_ENTRIES-1:0]              apply;
  logic [N_ENTRIES-1:0][TID_W-1:0]   owner;
  logic [N_ENTRIES-1:0][LOCK_W-1:0]  lock_id;
  logic [N_ENTRIES-1:0][ACC_W-1:0]   acc;
  logic [EIDX_W-1:0]                 best_idx;
  logic [ACC_W-1:0]                  best_acc;
  logic [N_THREADS-1:0]              flags_n;

  lli_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary)
  );

  assign evt_ready = !boundary;
  assign fire      = evt_valid && evt_ready;
  assign hit       = |match;

  // lowest free entry for a lock not yet tracked
  always_comb begin
    alloc_oh = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (!busy[i] && (alloc_oh == '0)) alloc_oh[i] = 1'b1;
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    assign match[g] = busy[g] && (lock_id[g] == evt_lock);
    assign apply[g] = fire && (match[g] || (!hit && alloc_oh[g]));

    lli_lock_entry #(
      .N_THREADS (N_THREADS),
      .LOCK_W    (LOCK_W),
      .ACC_W     (ACC_W),
      .TID_W     (TID_W)
    ) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (boundary),
      .apply    (apply[g]),
      .alloc    (!hit && alloc_oh[g]),
      .kind     (evt_kind),
      .tid      (evt_thread),
      .lock_in  (evt_lock),
      .busy     (busy[g]),
      .lock_id  (lock_id[g]),
      .owned    (owned[g]),
      .owner    (owner[g]),
      .wait_acc (acc[g])
    );
  end

  lli_max_select #(
    .N_ENTRIES (N_ENTRIES),
    .ACC_W     (ACC_W),
    .EIDX_W    (EIDX_W)
  ) u_select (
    .vals (acc),
    .idx  (best_idx),
    .best (best_acc)
  );

  always_comb begin
    flags_n = '0;
    if ((best_acc != '0) && owned[best_idx]) flags_n[owner[best_idx]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limiter_flags <= '0;
      limiter_upd   <= 1'b0;
    end else begin
      limiter_upd <= boundary;
      if (boundary) limiter_flags <= flags_n;
    end
  end
endmodule

// File: rtl/lock_limiter_id_chk.sv
module lock_limiter_id_chk #(
  parameter int N_THREADS = 16,
  parameter int INTERVAL  = 100000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 evt_ready,
  input logic [N_THREADS-1:0] limiter_flags,
  input logic                 limiter_upd
);
  localparam int GW = $clog2(INTERVAL + 1) + 1;

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (limiter_upd) gap <= GW'(1);
    else if (gap != '1) gap <= gap + 1'b1;
  end

  AST_FLAGS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(limiter_flags)); // R4

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !limiter_upd |-> $stable(limiter_flags)); // R3

  AST_READY_SINGLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ready |=> evt_ready); // R1

  AST_UPD_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ready |=> limiter_upd); // R3

  AST_UPD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    limiter_upd |-> (gap == GW'(INTERVAL))); // R3
endmodule

bind lock_limiter_id lock_limiter_id_chk #(
  .N_THREADS (N_THREADS),
  .INTERVAL  (INTERVAL)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_ready     (evt_ready),
  .limiter_flags (limiter_flags),
  .limiter_upd   (limiter_upd)
);

// File: tb/lock_limiter_id_bench.sv
module lock_limiter_id_bench;
  localparam int NT = 4;
  localparam int NE = 4;
  localparam int LW = 8;
  localparam int AW = 6;
  localparam int IV = 64;
  localparam int TW = 2;

  localparam logic [1:0] K_TAKE = 2'd0;
  localparam logic [1:0] K_GIVE = 2'd1;
  localparam logic [1:0] K_WB   = 2'd2;
  localparam logic [1:0] K_WS   = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          evt_valid;
  logic          evt_ready;
  logic [1:0]    evt_kind;
  logic [TW-1:0] evt_thread;
  logic [LW-1:0] evt_lock;
  logic [NT-1:0] limiter_flags;
  logic          limiter_upd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_upd_cyc = -1;
  bit done = 1'b0;

  logic [NT-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lock_limiter_id #(
    .N_THREADS (NT),
    .N_ENTRIES (NE),
    .LOCK_W    (LW),
    .ACC_W     (AW),
    .INTERVAL  (IV)
  ) u_lock_limiter_id (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_valid     (evt_valid),
    .evt_ready     (evt_ready),
    .evt_kind      (evt_kind),
    .evt_thread    (evt_thread),
    .evt_lock      (evt_lock),
    .limiter_flags (limiter_flags),
    .limiter_upd   (limiter_upd)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ev(input logic [1:0] k, input int t, input int l);
    evt_valid  = 1'b1;
    evt_kind   = k;
    evt_thread = TW'(t);
    evt_lock   = LW'(l);
    @(negedge clk);
    evt_valid  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_upd();
    do @(negedge clk); while (!limiter_upd);
  endtask

  task automatic expect_flags(input logic [NT-1:0] f, input string tag);
    exp_q.push_back(f);
    tag_q.push_back(tag);
  endtask

  // monitor: compares each new flag vector with the scoreboard
  always @(negedge clk) begin
    if (rst_n && limiter_upd) begin
      if (last_upd_cyc >= 0) check("R3 update period", cyc - last_upd_cyc, IV);
      last_upd_cyc = cyc;
      if (exp_q.size() == 0) begin
        check("R3 unexpected update", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'(limiter_flags), int'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    evt_valid = 1'b0;
    evt_kind = '0;
    evt_thread = '0;
    evt_lock = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 flags after reset", int'(limiter_flags), 0);
    check("R11 ready after reset", int'(evt_ready), 1);
    expect_flags(4'b0000, "R11 first interval");
    wait_upd();

    // S1: lock 10 owned by thread 1 with two waiters, lock 20 idle
    ev(K_TAKE, 1, 10);
    ev(K_WB, 0, 10);
    ev(K_WB, 2, 10);
    ev(K_TAKE, 3, 20);
    expect_flags(4'b0010, "R4 owner of busiest lock");
    wait_upd();

    // S2: previous totals gone (R7), foreign give-back ignored (R9)
    ev(K_WS, 0, 10);
    ev(K_WS, 2, 10);
    ev(K_WB, 0, 20);
    idle(20);
    ev(K_WS, 0, 20);
    ev(K_GIVE, 2, 20);
    expect_flags(4'b1000, "R7 R9 restart and foreign give-back");
    wait_upd();

    // S3: equal totals on entries 0 and 1, lowest index wins
    ev(K_WB, 0, 10);
    ev(K_WB, 2, 20);
    idle(10);
    ev(K_WS, 0, 10);
    ev(K_WS, 2, 20);
    expect_flags(4'b0010, "R5 tie to lowest entry");
    wait_upd();

    // S4: busiest lock has no owner; thread wait ends via R2 stop-wait
    ev(K_GIVE, 1, 10);
    ev(K_WB, 0, 10);
    idle(15);
    ev(K_WS, 0, 10);
    expect_flags(4'b0000, "R6 busiest lock unowned");
    wait_upd();

    // S5: both totals saturate, tie resolves to entry 0 (lock 30, owner 0)
    ev(K_TAKE, 0, 30);
    ev(K_TAKE, 1, 40);
    ev(K_TAKE, 2, 50);
    ev(K_WB, 1, 20);
    ev(K_WB, 2, 20);
    ev(K_WB, 0, 30);
    ev(K_WB, 3, 30);
    expect_flags(4'b0001, "R8 saturated totals tie");
    wait_upd();

    // S6: table full, lock 60 events dropped (R10)
    ev(K_WS, 1, 20);
    ev(K_WS, 2, 20);
    ev(K_WS, 0, 30);
    ev(K_WS, 3, 30);
    ev(K_WB, 1, 60);
    ev(K_WB, 2, 60);
    ev(K_WB, 3, 60);
    ev(K_WB, 0, 50);
    idle(20);
    ev(K_WS, 0, 50);
    ev(K_WS, 1, 60);
    ev(K_WS, 2, 60);
    ev(K_WS, 3, 60);
    expect_flags(4'b0100, "R10 full table drops new lock");
    // R1: offer an event in the selection cycle; it must be refused
    while (evt_ready) @(negedge clk);
    check("R1 ready low position", cyc - last_upd_cyc, IV - 1);
    ev(K_WB, 0, 40);

    // S7: nothing waits, so no flag (also shows R1 refusal)
    expect_flags(4'b0000, "R1 R6 event in selection cycle refused");
    wait_upd();
    @(negedge clk);
    check("R3 flags hold after update", int'(limiter_flags), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule